// File: doc/BRIEF.md
# Fractional-N PLL Frequency Evaluator

This block works out the output frequency, in hertz, of one fractional-N PLL from its settings: the reference oscillator frequency, an integer multiplier, a fractional multiplier, a post-divider, a prescaler-doubling bit and two lock-breaking conditions (powered down, analog reset). The multiplier is a fixed-point number. The integer part sits above `FRAC_W` fraction bits. The prescaler bit doubles the whole multiplier.

A one-cycle `start` pulse in the idle state captures the settings. The block forms the full-width product of reference and multiplier, divides it by the post-divider with a restoring shift-subtract loop that settles one quotient bit per cycle, and drops the fraction bits. When the PLL is not locked, or the post-divider is zero, the block skips the division and reports zero one cycle later. The result stays on `freq_hz` until a later computation replaces it. `done` pulses for one cycle each time a result is written.

Top module: `pllfe_eval`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `freq_hz` is 0.
- R2: With the PLL locked and `post_div` nonzero, the result is floor(floor(ref_hz × (int_mult·2^FRAC_W + frac_mult) / post_div) / 2^FRAC_W), computed without overflow over the whole input range.
- R3: When `prescale_en` is 1, both the integer and fractional multipliers are doubled before the product is formed.
- R4: If `pwr_down` or `ana_rst` is 1 when a start is accepted, `freq_hz` becomes 0 and `done` pulses in the next cycle, with `busy` staying 0.
- R5: A `post_div` of 0 at an accepted start gives the same zero result and one-cycle timing as R4, and no division takes place.
- R6: For a computation that divides, `busy` is high for exactly PROD_W+1 cycles after the accepting edge, and `done` rises in the first cycle with `busy` low. `done` is never high while `busy` is high.
- R7: `done` is high for one cycle only. `freq_hz` changes only in a cycle where `done` is high, and otherwise holds its value.
- R8: A `start` seen while `busy` is high is ignored. It neither restarts nor shortens the running computation, and it does not change the result.
- R9: The result depends only on the inputs sampled at the accepting edge. Changing the inputs while `busy` is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a computation (taken only when idle) |
| ref_hz | input | REF_W (32) | Reference oscillator frequency in Hz |
| int_mult | input | INT_W (10) | Integer part of the multiplier |
| frac_mult | input | FRAC_W (20) | Fractional part of the multiplier |
| post_div | input | DIV_W (3) | Post-divider, 0 forces a zero result |
| prescale_en | input | 1 | Double the multiplier |
| pwr_down | input | 1 | PLL powered down (not locked) |
| ana_rst | input | 1 | PLL analog reset asserted (not locked) |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse, new result on freq_hz |
| freq_hz | output | PROD_W-FRAC_W (44) | Computed output frequency in Hz |

## Verification
The hardest situations to reach from the ports are a start that arrives in the last cycles of a running division, and inputs that move while a division is still running. The bench reaches the first by holding `start` high for a long stretch across several computations, so that the request is present at every edge, including the wrap cycle and the cycle in which `done` is high. It reaches the second by changing every setting, and pulsing `start` with a zero-forcing setting, part way through a run. A behavioural model captures the inputs only at the edges where it accepts a request, and the bench compares against it on every clock.

// File: rtl/pllfe_pkg.sv
package pllfe_pkg;

  // Control phases of the evaluator
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,   // waiting for a request
    PH_RUN  = 2'd1,   // divider iterating
    PH_WRAP = 2'd2    // quotient ready, publish result
  } pllfe_phase_e;

endpackage

// File: rtl/pllfe_qualify.sv
// Decides whether a request bypasses the divider with a zero result.
module pllfe_qualify #(
  parameter int DIV_W = 3
) (
  input  logic             pwr_down,
  input  logic             ana_rst,
  input  logic [DIV_W-1:0] post_div,
  output logic             unlocked,
  output logic             force_zero
);

  function automatic logic lock_lost(input logic pd, input logic ar);
    return pd | ar;
  endfunction

  assign unlocked   = lock_lost(pwr_down, ana_rst);
  assign force_zero = unlocked | (post_div == '0);

endmodule

// File: rtl/pllfe_scale.sv
// Forms the fixed-point multiplier and the full-width product.
module pllfe_scale #(
  parameter int REF_W  = 32,
  parameter int INT_W  = 10,
  parameter int FRAC_W = 20,
  parameter int PROD_W = 64,
  localparam int MUL_W = INT_W + FRAC_W + 1
) (
  input  logic [REF_W-1:0]  ref_hz,
  input  logic [INT_W-1:0]  int_mult,
  input  logic [FRAC_W-1:0] frac_mult,
  input  logic              prescale_en,
  output logic [MUL_W-1:0]  mult_word,
  output logic [PROD_W-1:0] product
);

  // integer part placed above the fraction bits, optionally doubled
  function automatic logic [MUL_W-1:0] build_mult(
    input logic [INT_W-1:0]  ip,
    input logic [FRAC_W-1:0] fp,
    input logic              dbl
  );
    logic [MUL_W-1:0] w;
    w = {1'b0, ip, fp};
    if (dbl) w = {ip, fp, 1'b0};
    return w;
  endfunction

  function automatic logic [PROD_W-1:0] widen_mul(
    input logic [REF_W-1:0] a,
    input logic [MUL_W-1:0] b
  );
    return PROD_W'(a) * PROD_W'(b);
  endfunction

  assign mult_word = build_mult(int_mult, frac_mult, prescale_en);
  assign product   = widen_mul(ref_hz, mult_word);

endmodule

// File: rtl/pllfe_divider.sv
// Restoring shift-subtract divider, one quotient bit per clock.
module pllfe_divider #(
  parameter int N  = 64,
  parameter int DW = 3,
  localparam int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N-1:0]  dividend,
  input  logic [DW-1:0] divisor,
  output logic          running,
  output logic          last_step,
  output logic [N-1:0]  quotient
);

  logic [N-1:0]  quo_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          fits;

  function automatic logic [DW:0] sub_try(input logic [DW:0] t, input logic [DW-1:0] d);
    return t - {1'b0, d};
  endfunction

  assign trial     = {rem_q, quo_q[N-1]};
  assign fits      = trial >= {1'b0, dvs_q};
  assign diff      = sub_try(trial, dvs_q);
  assign last_step = run_q && (cnt_q == CW'(N - 1));
  assign running   = run_q;
  assign quotient  = quo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      quo_q <= dividend;
      rem_q <= '0;
      dvs_q <= divisor;
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      quo_q <= {quo_q[N-2:0], fits};
      rem_q <= fits ? diff[DW-1:0] : trial[DW-1:0];
      cnt_q <= cnt_q + 1'b1;
      if (last_step) run_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pllfe_eval.sv
// Top: fractional-N PLL output frequency evaluator.
module pllfe_eval #(
  parameter int REF_W  = 32,
  parameter int INT_W  = 10,
  parameter int FRAC_W = 20,
  parameter int DIV_W  = 3,
  parameter int PROD_W = 64,
  localparam int OUT_W = PROD_W - FRAC_W,
  localparam int MUL_W = INT_W + FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REF_W-1:0]  ref_hz,
  input  logic [INT_W-1:0]  int_mult,
  input  logic [FRAC_W-1:0] frac_mult,
  input  logic [DIV_W-1:0]  post_div,
  input  logic              prescale_en,
  input  logic              pwr_down,
  input  logic              ana_rst,
  output logic              busy,
  output logic              done,
  output logic [OUT_W-1:0]  freq_hz
);
  import pllfe_pkg::*;

  pllfe_phase_e      phase_q;
  logic [OUT_W-1:0]  res_q;
  logic              done_q;

  logic              unlocked;
  logic              force_zero;
  logic [MUL_W-1:0]  mult_word;
  logic [PROD_W-1:0] product;
  logic              div_running;
  logic              div_last;
  logic [PROD_W-1:0] div_quo;

  // named events for the checker
  logic              start_ok;
  logic              div_load;

  assign start_ok = start && (phase_q == PH_IDLE);
  assign div_load = start_ok && !force_zero;

  pllfe_qualify #(.DIV_W(DIV_W)) qual_i (
    .pwr_down   (pwr_down),
    .ana_rst    (ana_rst),
    .post_div   (post_div),
    .unlocked   (unlocked),
    .force_zero (force_zero)
  );

  pllfe_scale #(
    .REF_W(REF_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .PROD_W(PROD_W)
  ) scale_i (
    .ref_hz      (ref_hz),
    .int_mult    (int_mult),
    .frac_mult   (frac_mult),
    .prescale_en (prescale_en),
    .mult_word   (mult_word),
    .product     (product)
  );

  pllfe_divider #(.N(PROD_W), .DW(DIV_W)) div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (div_load),
    .dividend  (product),
    .divisor   (post_div),
    .running   (div_running),
    .last_step (div_last),
    .quotient  (div_quo)
  );

  function automatic logic [OUT_W-1:0] drop_frac(input logic [PROD_W-1:0] q);
    return q[PROD_W-1:FRAC_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_ok) begin
            if (force_zero) begin
              res_q  <= '0;
              done_q <= 1'b1;
            end else begin
              phase_q <= PH_RUN;
            end
          end
        end
        PH_RUN: begin
          if (div_last) phase_q <= PH_WRAP;
        end
        PH_WRAP: begin
          res_q   <= drop_frac(div_quo);
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy    = (phase_q != PH_IDLE);
  assign done    = done_q;
  assign freq_hz = res_q;

endmodule

// File: rtl/pllfe_eval_chk.sv
module pllfe_eval_chk #(
  parameter int DIV_W  = 3,
  parameter int PROD_W = 64,
  parameter int OUT_W  = 44,
  localparam int LAT   = PROD_W + 1,
  localparam int CNT_W = $clog2(LAT + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pwr_down,
  input logic             ana_rst,
  input logic [DIV_W-1:0] post_div,
  input logic             busy,
  input logic             done,
  input logic [OUT_W-1:0] freq_hz,
  input logic             div_running
);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     run_cnt <= '0;
    else if (busy)  run_cnt <= run_cnt + 1'b1;
    else            run_cnt <= '0;
  end

  // R4
  zero_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (pwr_down || ana_rst)) |=> (done && !busy && freq_hz == '0));

  // R5
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && post_div == '0) |=> (done && !div_running && freq_hz == '0));

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && run_cnt == CNT_W'(LAT)));

  // R6
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_hz) |-> done);

  // R8
  no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_cnt < CNT_W'(LAT - 1)) |=> busy);

endmodule

bind pllfe_eval pllfe_eval_chk #(
  .DIV_W(DIV_W), .PROD_W(PROD_W), .OUT_W(OUT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .pwr_down    (pwr_down),
  .ana_rst     (ana_rst),
  .post_div    (post_div),
  .busy        (busy),
  .done        (done),
  .freq_hz     (freq_hz),
  .div_running (div_running)
);

// File: tb/pllfe_eval_tb_top.sv
`timescale 1ns/1ps
module pllfe_eval_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = 32'd19200000;
  logic [9:0]  int_mult = '0;
  logic [19:0] frac_mult = '0;
  logic [2:0]  post_div = '0;
  logic        prescale_en = 1'b0;
  logic        pwr_down = 1'b0;
  logic        ana_rst = 1'b0;
  logic        busy;
  logic        done;
  logic [43:0] freq_hz;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  pllfe_eval dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz),
    .int_mult(int_mult), .frac_mult(frac_mult), .post_div(post_div),
    .prescale_en(prescale_en), .pwr_down(pwr_down), .ana_rst(ana_rst),
    .busy(busy), .done(done), .freq_hz(freq_hz)
  );

  // expected frequency, written from the requirement text (R2, R3, R4, R5)
  function automatic logic [63:0] expect_hz(
    input logic [31:0] r, input logic [9:0] im, input logic [19:0] fm,
    input logic [2:0] pd_v, input logic pre, input logic dn, input logic ar);
    logic [63:0] m;
    logic [63:0] p;
    if (dn || ar || pd_v == 3'd0) return 64'd0;
    m = {34'd0, im, fm};
    if (pre) m = m + m;
    p = {32'd0, r} * m;
    p = p / {61'd0, pd_v};
    return p >> 20;
  endfunction

  // behavioural model, accepts only when idle
  logic        m_busy;
  logic        m_done;
  logic [43:0] m_freq;
  logic [43:0] m_pend;
  int          m_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_freq <= '0; m_pend <= '0; m_left <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy) begin
        if (start) begin
          if (pwr_down || ana_rst || post_div == 3'd0) begin
            m_freq <= '0;
            m_done <= 1'b1;
          end else begin
            m_pend <= expect_hz(ref_hz, int_mult, frac_mult, post_div,
                                prescale_en, pwr_down, ana_rst)[43:0];
            m_busy <= 1'b1;
            m_left <= 65;
          end
        end
      end else if (m_left == 1) begin
        m_busy <= 1'b0;
        m_done <= 1'b1;
        m_freq <= m_pend;
        m_left <= 0;
      end else begin
        m_left <= m_left - 1;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cur_req, "done", {63'd0, done}, {63'd0, m_done});
      check(cur_req, "busy", {63'd0, busy}, {63'd0, m_busy});
      check(cur_req, "freq_hz", {20'd0, freq_hz}, {20'd0, m_freq});
    end
  end

  task automatic setup(input logic [31:0] r, input logic [9:0] im,
                       input logic [19:0] fm, input logic [2:0] pd_v,
                       input logic pre, input logic dn, input logic ar);
    ref_hz = r; int_mult = im; frac_mult = fm; post_div = pd_v;
    prescale_en = pre; pwr_down = dn; ana_rst = ar;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy || busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_case(input string req, input logic [31:0] r,
                          input logic [9:0] im, input logic [19:0] fm,
                          input logic [2:0] pd_v, input logic pre,
                          input logic dn, input logic ar);
    logic [63:0] e;
    cur_req = req;
    setup(r, im, fm, pd_v, pre, dn, ar);
    e = expect_hz(r, im, fm, pd_v, pre, dn, ar);
    pulse_start();
    wait_idle();
    check(req, "final result", {20'd0, freq_hz}, e);
  endtask

  // watchdog
  initial begin
    while (cycles < 150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "done at reset", {63'd0, done}, 64'd0);
    check("R1", "busy at reset", {63'd0, busy}, 64'd0);
    check("R1", "freq at reset", {20'd0, freq_hz}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: plain locked cases
    run_case("R2", 32'd19200000, 10'd52, 20'h55555, 3'd1, 1'b0, 1'b0, 1'b0);
    run_case("R2", 32'd19200000, 10'd100, 20'd12345, 3'd3, 1'b0, 1'b0, 1'b0);
    run_case("R2", 32'd1000000, 10'd7, 20'hFFFFF, 3'd7, 1'b0, 1'b0, 1'b0);
    // R2 boundary: widest product
    run_case("R2", 32'hFFFFFFFF, 10'h3FF, 20'hFFFFF, 3'd1, 1'b1, 1'b0, 1'b0);
    run_case("R2", 32'hFFFFFFFF, 10'h3FF, 20'hFFFFF, 3'd7, 1'b1, 1'b0, 1'b0);
    // R3: prescaler doubles integer and fraction
    run_case("R3", 32'd19200000, 10'd52, 20'h80001, 3'd5, 1'b1, 1'b0, 1'b0);
    run_case("R3", 32'd3, 10'd0, 20'd1, 3'd1, 1'b1, 1'b0, 1'b0);
    // R4: not locked
    run_case("R4", 32'd19200000, 10'd52, 20'd0, 3'd2, 1'b0, 1'b1, 1'b0);
    run_case("R4", 32'd19200000, 10'd52, 20'd0, 3'd2, 1'b1, 1'b0, 1'b1);
    // R5: post-divider zero
    run_case("R5", 32'd19200000, 10'd52, 20'd9, 3'd0, 1'b0, 1'b0, 1'b0);

    // R6: latency of a dividing run
    begin
      int seen;
      cur_req = "R6";
      setup(32'd24000000, 10'd40, 20'd0, 3'd2, 1'b0, 1'b0, 1'b0);
      pulse_start();
      seen = 1;
      while (busy) begin @(negedge clk); seen++; end
      check("R6", "busy cycles", 64'(seen - 1), 64'd65);
      check("R6", "done after busy", {63'd0, done}, 64'd1);
      check("R6", "result", {20'd0, freq_hz}, 64'd480000000);
      wait_idle();
    end

    // R7: result holds with no start
    begin
      logic [43:0] held;
      cur_req = "R7";
      held = freq_hz;
      setup(32'd5, 10'd1, 20'd0, 3'd1, 1'b0, 1'b1, 1'b0);
      repeat (10) @(negedge clk);
      check("R7", "held result", {20'd0, freq_hz}, {20'd0, held});
      check("R7", "no done", {63'd0, done}, 64'd0);
    end

    // R8 and R9: stimulus while busy
    begin
      cur_req = "R9";
      setup(32'd19200000, 10'd60, 20'd777, 3'd3, 1'b0, 1'b0, 1'b0);
      pulse_start();
      repeat (5) @(negedge clk);
      setup(32'd1, 10'd2, 20'd3, 3'd0, 1'b1, 1'b1, 1'b1);
      cur_req = "R8";
      pulse_start();
      repeat (50) @(negedge clk);
      pulse_start();
      wait_idle();
      check("R8", "ignored start result", {20'd0, freq_hz},
            expect_hz(32'd19200000, 10'd60, 20'd777, 3'd3, 1'b0, 1'b0, 1'b0));
    end

    // R8: start held high across done and wrap cycles
    begin
      cur_req = "R8";
      setup(32'd27000000, 10'd33, 20'd4096, 3'd6, 1'b0, 1'b0, 1'b0);
      @(negedge clk); start = 1'b1;
      repeat (200) @(negedge clk);
      start = 1'b0;
      wait_idle();
      check("R8", "held-start result", {20'd0, freq_hz},
            expect_hz(32'd27000000, 10'd33, 20'd4096, 3'd6, 1'b0, 1'b0, 1'b0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule